// File: doc/BRIEF.md
# Runtime-Selectable Sinc-Cubed Decimator

This block turns the single-bit output of a second-order sigma-delta modulator into signed 16-bit PCM samples. It is a third-order cascaded integrator-comb filter: three integrators run at the modulator rate and three differencing stages run at the output rate. One 2-bit select input sets the decimation ratio at run time to one of four powers of two, and all four share the same integrator/comb hardware.

Each modulator sample is presented with a one-cycle clock enable. With a 2.048 MHz modulator rate, the four ratios give 64, 32, 16 and 8 kHz output rates. The filter output is shifted right by an amount that depends on the ratio, so that full scale always lands at 16 bits. The result is then clamped to the 16-bit range. Each output sample comes with a single-cycle valid strobe. Changing the select value clears the filter state and holds back the first three outputs that follow, because those outputs are still settling.

Top module: `sinc3_decim`

## Requirements
- R1: Once the filter has settled, an input stream that repeats with a period dividing the ratio and has a fraction p of ones gives the output value 32768·(2p−1), clamped as in R5.
- R2: An input bit of 1 counts as +1 and a bit of 0 counts as −1, so a stream of all zeros gives −32768.
- R3: Select codes 0, 1, 2 and 3 choose ratios 32, 64, 128 and 256. Settled valid strobes are exactly ratio × (clocks per enable) cycles apart.
- R4: The same input pattern gives the same output value at every ratio, because of the ratio-dependent right shift of 3·log2(ratio) − 15.
- R5: Results above 32767 are clamped to 32767 and results below −32768 are clamped to −32768, keeping the sign. A stream of all ones gives 32767.
- R6: A change of the select input clears the filter. The first valid output after the change then appears after exactly 4·ratio accepted enables, because three outputs are suppressed.
- R7: valid_o is high for exactly one clock cycle per sample, and pcm_o holds its value between strobes.
- R8: After reset, pcm_o is 0 and valid_o is 0. The block runs at select code 0, and its first valid output comes after 4·32 enables.
- R9: bit_i is ignored in cycles where ce_i is low.
- R10: The accumulators wrap in two's complement and are 3·8+2 bits wide, so outputs at ratio 256 are exact despite the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Modulator-rate sample enable |
| bit_i | input | 1 | Modulator bitstream |
| rate_sel_i | input | 2 | Decimation ratio select (code n gives 32·2^n) |
| pcm_o | output | 16 | Signed output sample |
| valid_o | output | 1 | One-cycle strobe for each new sample |

## Verification
The assertions take for granted that ce_i pulses are separated by at least one idle cycle. They also assume that rate_sel_i changes only in a cycle where ce_i is low, so that no sample is lost in the flush. The stimulus follows both rules: it raises ce_i on every fourth cycle only, and it changes the select value only while the enable is low. It also fills the idle cycles with random bit_i values so that R9 is exercised. The input patterns are periodic with periods of 1, 2, 4 or 8. Their settled outputs therefore do not depend on the phase, which lets every expected value be written in closed form.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

  function automatic int ratio_log2(input int min_log2, input int sel);
    return min_log2 + sel;
  endfunction

  // right shift that brings full scale (ratio^stages) down to 2^(pcm_w-1)
  function automatic int out_shift(input int stages, input int rlog2, input int pcm_w);
    int s;
    s = stages * rlog2 - (pcm_w - 1);
    return (s < 0) ? 0 : s;
  endfunction

endpackage

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
  parameter int ACC_W  = 26,
  parameter int STAGES = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    ce_i,
  input  logic                    bit_i,
  output logic signed [ACC_W-1:0] acc_o
);

  logic signed [ACC_W-1:0] acc_q [STAGES];
  logic signed [ACC_W-1:0] in_w  [STAGES];

  assign in_w[0] = bit_i ? ACC_W'(1) : '1;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g > 0) begin : g_chain
      assign in_w[g] = acc_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    acc_q[g] <= '0;
      else if (clr_i) acc_q[g] <= '0;
      else if (ce_i)  acc_q[g] <= acc_q[g] + in_w[g];
    end
  end

  assign acc_o = acc_q[STAGES-1];

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_i && !clr_i) |=> $stable(acc_o));

endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
  parameter int ACC_W  = 26,
  parameter int STAGES = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    dec_i,
  input  logic signed [ACC_W-1:0] acc_i,
  output logic signed [ACC_W-1:0] y_o,
  output logic                    vld_o
);

  logic signed [ACC_W-1:0] dly_q  [STAGES];
  logic signed [ACC_W-1:0] diff_w [STAGES+1];

  assign diff_w[0] = acc_i;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    assign diff_w[g+1] = diff_w[g] - dly_q[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    dly_q[g] <= '0;
      else if (clr_i) dly_q[g] <= '0;
      else if (dec_i) dly_q[g] <= diff_w[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_o   <= '0;
      vld_o <= 1'b0;
    end else if (clr_i) begin
      y_o   <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= dec_i;
      if (dec_i) y_o <= diff_w[STAGES];
    end
  end

  // R7
  comb_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> $past(dec_i));

endmodule

// File: rtl/sinc3_scale.sv
module sinc3_scale
  import sinc3_pkg::*;
#(
  parameter int ACC_W    = 26,
  parameter int PCM_W    = 16,
  parameter int SEL_W    = 2,
  parameter int MIN_LOG2 = 5,
  parameter int STAGES   = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    vld_i,
  input  logic signed [ACC_W-1:0] y_i,
  input  logic [SEL_W-1:0]        sel_i,
  output logic signed [PCM_W-1:0] pcm_o,
  output logic                    vld_o
);

  localparam logic signed [ACC_W-1:0] POS_LIM = ACC_W'((64'sd1 <<< (PCM_W-1)) - 1);
  localparam logic signed [ACC_W-1:0] NEG_LIM = -POS_LIM - ACC_W'(1);

  logic signed [ACC_W-1:0] shifted;
  logic signed [PCM_W-1:0] sat_w;

  always_comb begin
    int sh;
    sh      = out_shift(STAGES, ratio_log2(MIN_LOG2, int'(sel_i)), PCM_W);
    shifted = y_i >>> sh;
    if (shifted > POS_LIM)      sat_w = POS_LIM[PCM_W-1:0];
    else if (shifted < NEG_LIM) sat_w = NEG_LIM[PCM_W-1:0];
    else                        sat_w = shifted[PCM_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcm_o <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) pcm_o <= sat_w;
    end
  end

  // R5
  sign_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && y_i[ACC_W-1]) |=> pcm_o[PCM_W-1]);

  // R7
  hold_between_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> $stable(pcm_o));

endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim #(
  parameter int SEL_W    = 2,
  parameter int MIN_LOG2 = 5,
  parameter int STAGES   = 3,
  parameter int PCM_W    = 16,
  parameter int SKIP_OUT = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ce_i,
  input  logic                    bit_i,
  input  logic [SEL_W-1:0]        rate_sel_i,
  output logic signed [PCM_W-1:0] pcm_o,
  output logic                    valid_o
);

  localparam int MAX_LOG2 = MIN_LOG2 + (1 << SEL_W) - 1;
  localparam int ACC_W    = STAGES * MAX_LOG2 + 2;
  localparam int CNT_W    = MAX_LOG2;
  localparam int SKIP_W   = $clog2(SKIP_OUT + 1);

  logic [SEL_W-1:0]        rate_q;
  logic                    flush;
  logic [CNT_W-1:0]        dcnt_q, last_cnt;
  logic                    dec_q;
  logic [SKIP_W-1:0]       skip_q;
  logic signed [ACC_W-1:0] acc3, comb_y;
  logic                    comb_vld, out_ok;

  assign flush = (rate_sel_i != rate_q);

  always_comb begin
    last_cnt = {CNT_W{1'b1}} >> (MAX_LOG2 - MIN_LOG2 - int'(rate_q));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q <= '0;
      dcnt_q <= '0;
      dec_q  <= 1'b0;
    end else if (flush) begin
      rate_q <= rate_sel_i;
      dcnt_q <= '0;
      dec_q  <= 1'b0;
    end else begin
      dec_q <= 1'b0;
      if (ce_i) begin
        if (dcnt_q == last_cnt) begin
          dcnt_q <= '0;
          dec_q  <= 1'b1;
        end else begin
          dcnt_q <= dcnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      skip_q <= SKIP_W'(SKIP_OUT);
    else if (flush)                   skip_q <= SKIP_W'(SKIP_OUT);
    else if (comb_vld && skip_q != 0) skip_q <= skip_q - 1'b1;
  end

  assign out_ok = comb_vld && (skip_q == 0) && !flush;

  sinc3_integ #(.ACC_W(ACC_W), .STAGES(STAGES)) u_integ (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (flush),
    .ce_i  (ce_i),
    .bit_i (bit_i),
    .acc_o (acc3)
  );

  sinc3_comb #(.ACC_W(ACC_W), .STAGES(STAGES)) u_comb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (flush),
    .dec_i (dec_q),
    .acc_i (acc3),
    .y_o   (comb_y),
    .vld_o (comb_vld)
  );

  sinc3_scale #(
    .ACC_W(ACC_W), .PCM_W(PCM_W), .SEL_W(SEL_W),
    .MIN_LOG2(MIN_LOG2), .STAGES(STAGES)
  ) u_scale (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (out_ok),
    .y_i   (comb_y),
    .sel_i (rate_q),
    .pcm_o (pcm_o),
    .vld_o (valid_o)
  );

  // R7
  one_cycle_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R3
  dec_after_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_q |-> $past(ce_i));

  // R3
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dcnt_q <= last_cnt);

  // R6
  flush_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> !valid_o);

  // R6
  skip_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (comb_vld && skip_q != 0) |=> !valid_o);

endmodule

// File: tb/sim_sinc3_decim.sv
module sim_sinc3_decim;

  localparam int CE_DIV = 4;

  typedef struct {
    int    val;
    int    ratio;
    bit    first;
    string tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce = 1'b0;
  logic        bit_in = 1'b0;
  logic [1:0]  rate_sel = 2'd0;
  logic signed [15:0] pcm;
  logic        valid;

  item_t exp_q[$];
  int n_cmp = 0, n_bad = 0;
  int ce_cnt = 0, cyc = 0, last_v = 0;
  bit prev_valid = 1'b0, done = 1'b0;

  always #4 clk = ~clk;

  sinc3_decim u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .ce_i      (ce),
    .bit_i     (bit_in),
    .rate_sel_i(rate_sel),
    .pcm_o     (pcm),
    .valid_o   (valid)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: queue expected results, then feed the pattern until all are seen
  task automatic run_case(input int sel, input logic [7:0] pat, input int plen,
                          input int nout, input int expv, input string tag);
    int ph = 0, idx = 0;
    @(negedge clk);
    rate_sel = 2'(sel);
    ce = 1'b0;
    ce_cnt = 0;
    for (int k = 0; k < nout; k++) begin
      item_t it;
      it.val = expv; it.ratio = 32 << sel; it.first = (k == 0); it.tag = tag;
      exp_q.push_back(it);
    end
    while (exp_q.size() != 0) begin
      @(negedge clk);
      ph++;
      if (ph == CE_DIV) begin
        ph = 0;
        ce = 1'b1;
        bit_in = pat[idx % plen];
        idx++;
        ce_cnt++;
      end else begin
        ce = 1'b0;
        bit_in = 1'($urandom); // R9: ignored while ce is low
      end
    end
    @(negedge clk);
    ce = 1'b0;
  endtask

  // monitor
  always begin
    @(posedge clk);
    #2;
    cyc++;
    if (rst_n) begin
      if (valid && prev_valid) check(1'b0, "R7 strobe width", 1, 0);
      if (valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected output", int'(pcm), 0);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          check(int'(pcm) == it.val, it.tag, int'(pcm), it.val);
          if (it.first)
            check(ce_cnt == 4 * it.ratio, "R6 first-output latency", ce_cnt, 4 * it.ratio);
          else
            check(cyc - last_v == it.ratio * CE_DIV, "R3 output spacing",
                  cyc - last_v, it.ratio * CE_DIV);
        end
        last_v = cyc;
      end
    end
    prev_valid = valid;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8
    check(pcm == 16'sd0, "R8 reset pcm", int'(pcm), 0);
    check(valid == 1'b0, "R8 reset valid", int'(valid), 0);
    @(negedge clk);
    rst_n = 1'b1;

    run_case(0, 8'hFF, 1, 3, 32767,  "R5 R8 all ones, ratio 32");
    run_case(1, 8'h07, 4, 3, 16384,  "R1 R3 three quarters, ratio 64");
    run_case(2, 8'h01, 4, 3, -16384, "R1 R4 one quarter, ratio 128");
    run_case(3, 8'h1F, 8, 3, 8192,   "R1 R10 five eighths, ratio 256");
    run_case(2, 8'h00, 1, 3, -32768, "R2 all zeros, ratio 128");
    run_case(0, 8'h02, 2, 3, 0,      "R1 R9 alternating, ratio 32");
    run_case(3, 8'hFF, 1, 3, 32767,  "R5 R10 all ones, ratio 256");
    run_case(1, 8'h00, 1, 3, -32768, "R2 R4 all zeros, ratio 64");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule